// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside the sequencer of an 8-bit CPU core and decides which of five interrupt sources is served next. One source cannot be masked. Three sources are restart-style inputs with fixed vectors. The fifth is a general request whose target comes from an instruction that the requesting device places on the bus. Each source has its own trigger rule: the non-maskable input needs a rising edge and a level that is still high, the highest maskable input latches its rising edge, and the remaining inputs are plain levels. Three mask bits and a global enable flag gate the maskable sources, and a fixed priority picks the winner.

The core sees a request flag and a 16-bit vector. At an instruction boundary it pulses `accept_i` to take the request. Taking a restart source clears the matching edge latch where there is one. Taking any maskable source also drops the global enable. Taking the general request produces a one-cycle acknowledge strobe instead of a useful vector. A configuration write loads the masks and can flush the latched high-priority edge. An 8-bit status word shows the enable flag, the masks and the pending state of the three restart inputs. A power-down flag that the core sets is cleared by a pending non-maskable request.

Top module: `vect_irq_ctrl`

## Requirements
- R1: After reset `irq_pend_o`=0, `irq_vec_o`=0x0000, `ext_ack_o`=0, `napping_o`=0, and `status_o`=0x07. All masks are set, the enable flag is clear and nothing is pending.
- R2: A rising edge on `nm_req_i` that is still high raises `irq_pend_o` with vector 0x0024 one clock edge later, whatever the masks and enable flag are. If the input falls before acceptance, the request drops. Acceptance removes the request, and a held-high input does not request again until it has fallen and risen.
- R3: A rising edge on `vq_hi_i` sets a pending latch (status bit 6) even while that input is masked or disabled. The latch holds after the input falls. When the input is unmasked and enabled it requests vector 0x003C.
- R4: The `vq_hi_i` latch is cleared when its request is accepted, or by a configuration write with bit 4 set.
- R5: `vq_mid_i` and `vq_lo_i` are level inputs. Status bits 5 and 4 follow them one edge later, and they request vectors 0x0034 and 0x002C respectively.
- R6: `ext_req_i`, when enabled, requests with vector 0x0000. Accepting it drives `ext_ack_o` high for exactly the cycle after the accepting edge.
- R7: A configuration write with bit 3 set loads the masks from bits 2 (high), 1 (mid) and 0 (low); with bit 3 clear the masks are unchanged. A masked input makes no request but still shows as pending. Status layout: bits 2..0 masks, bit 3 enable, bits 6..4 pending high, mid, low, bit 7 zero.
- R8: `en_set_i` sets the enable flag and `en_clr_i` clears it. While it is clear, no maskable source requests.
- R9: Accepting any maskable request clears the enable flag. Accepting the non-maskable request leaves it unchanged.
- R10: Fixed priority, highest first: non-maskable, high, mid, low, general.
- R11: `nap_i` sets `napping_o`. A pending non-maskable request clears it one edge later. Maskable requests do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nm_req_i | input | 1 | Non-maskable request, edge and level |
| vq_hi_i | input | 1 | Highest restart input, rising edge latched |
| vq_mid_i | input | 1 | Middle restart input, level |
| vq_lo_i | input | 1 | Lowest restart input, level |
| ext_req_i | input | 1 | General request, level, vector supplied externally |
| accept_i | input | 1 | Core takes the current request |
| en_set_i | input | 1 | Set global enable |
| en_clr_i | input | 1 | Clear global enable |
| cfg_we_i | input | 1 | Mask/flush write strobe |
| cfg_wdata_i | input | 8 | Write word: bit 4 flush, bit 3 load masks, bits 2..0 masks |
| nap_i | input | 1 | Core enters power-down |
| irq_pend_o | output | 1 | A request is presented |
| irq_vec_o | output | 16 | Vector of the winning source, 0 if none or general |
| ext_ack_o | output | 1 | Acknowledge strobe for the general request |
| status_o | output | 8 | Enable, masks and pending state |
| napping_o | output | 1 | Power-down flag |

## Verification
The hardest case to reach is a stack of simultaneous requests in which each winner is removed in turn by its own clearing rule. The stimulus holds the mid, low and general inputs high together. It then adds a latched high edge and a non-maskable edge, so that the vector moves through 0x0034, 0x003C and 0x0024. Acceptances then peel the stack back. The non-maskable acceptance must leave the enable flag set, and the next acceptance must clear both the high latch and the enable flag. Mask writes then expose the low and general sources one after the other.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC   = 5;
  localparam int IDX_W   = $clog2(N_SRC);
  localparam int VEC_W   = 16;
  localparam int CSR_W   = 8;
  localparam int N_MASK  = 3;

  localparam int SRC_NM  = 0;
  localparam int SRC_HI  = 1;
  localparam int SRC_MID = 2;
  localparam int SRC_LO  = 3;
  localparam int SRC_EXT = 4;

  localparam int CFG_APPLY = 3;
  localparam int CFG_FLUSH = 4;

  typedef enum logic [1:0] {
    TRG_EDGE_LVL,
    TRG_EDGE_HOLD,
    TRG_LVL
  } trig_e;

  function automatic trig_e trig_of(input int idx);
    if (idx == SRC_NM) return TRG_EDGE_LVL;
    if (idx == SRC_HI) return TRG_EDGE_HOLD;
    return TRG_LVL;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(SRC_NM):  vec_of = VEC_W'(16'h0024);
      IDX_W'(SRC_HI):  vec_of = VEC_W'(16'h003C);
      IDX_W'(SRC_MID): vec_of = VEC_W'(16'h0034);
      IDX_W'(SRC_LO):  vec_of = VEC_W'(16'h002C);
      default:         vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_sense.sv
module irq_sense
  import irq_pkg::*;
#(
  parameter trig_e KIND = TRG_LVL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic clr_i,
  output logic pend_o
);
  logic smp_q;
  logic rise;

  assign rise = raw_i & ~smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= raw_i;
  end

  generate
    if (KIND == TRG_LVL) begin : g_lvl
      logic unused_lvl;
      assign unused_lvl = rise | clr_i;
      assign pend_o = smp_q;
    end else begin : g_edge
      logic lat_q, lat_d;
      always_comb begin
        lat_d = lat_q;
        if (clr_i) lat_d = 1'b0;
        if (rise)  lat_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= 1'b0;
        else        lat_q <= lat_d;
      end
      if (KIND == TRG_EDGE_LVL) begin : g_and
        assign pend_o = lat_q & smp_q;
      end else begin : g_hold
        assign pend_o = lat_q;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_pkg::*;
(
  input  logic [N_SRC-1:0] ok_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (ok_i[i]) idx_o = IDX_W'(i);
    end
    valid_o = |ok_i;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              take_mask_i,
  input  logic              apply_i,
  input  logic [N_MASK-1:0] mask_wdata_i,
  input  logic              nap_i,
  input  logic              wake_i,
  output logic              ie_o,
  output logic [N_MASK-1:0] mask_o,
  output logic              napping_o
);
  logic              ie_q, ie_d;
  logic [N_MASK-1:0] mask_q, mask_d;
  logic              nap_q, nap_d;

  always_comb begin
    ie_d = ie_q;
    if (en_set_i)    ie_d = 1'b1;
    if (en_clr_i)    ie_d = 1'b0;
    if (take_mask_i) ie_d = 1'b0;
    mask_d = mask_q;
    if (apply_i) mask_d = mask_wdata_i;
    nap_d = nap_q;
    if (nap_i)  nap_d = 1'b1;
    if (wake_i) nap_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
      nap_q  <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      mask_q <= mask_d;
      nap_q  <= nap_d;
    end
  end

  assign ie_o      = ie_q;
  assign mask_o    = mask_q;
  assign napping_o = nap_q;
endmodule

// File: rtl/vect_irq_ctrl.sv
module vect_irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nm_req_i,
  input  logic             vq_hi_i,
  input  logic             vq_mid_i,
  input  logic             vq_lo_i,
  input  logic             ext_req_i,
  input  logic             accept_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             cfg_we_i,
  input  logic [CSR_W-1:0] cfg_wdata_i,
  input  logic             nap_i,
  output logic             irq_pend_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             ext_ack_o,
  output logic [CSR_W-1:0] status_o,
  output logic             napping_o
);
  logic [N_SRC-1:0]  raw, clr, pend, ok;
  logic [N_MASK-1:0] mask;
  logic              ie, valid, take, take_mask, flush;
  logic [IDX_W-1:0]  idx;
  logic              ack_q, ack_d;
  logic [CSR_W-1:0]  unused_wd;

  assign unused_wd = cfg_wdata_i & ~CSR_W'(8'h1F);
  assign raw   = {ext_req_i, vq_lo_i, vq_mid_i, vq_hi_i, nm_req_i};
  assign take  = accept_i & valid;
  assign take_mask = take & (idx != IDX_W'(SRC_NM));
  assign flush = cfg_we_i & cfg_wdata_i[CFG_FLUSH];

  always_comb begin
    clr = '0;
    clr[SRC_NM] = take & (idx == IDX_W'(SRC_NM));
    clr[SRC_HI] = (take & (idx == IDX_W'(SRC_HI))) | flush;
  end

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      irq_sense #(.KIND(trig_of(i))) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw[i]),
        .clr_i  (clr[i]),
        .pend_o (pend[i])
      );
      if (i == SRC_NM) begin : g_nm
        assign ok[i] = pend[i];
      end else if (i == SRC_EXT) begin : g_ext
        assign ok[i] = pend[i] & ie;
      end else begin : g_rst
        assign ok[i] = pend[i] & ie & ~mask[N_MASK - i];
      end
    end
  endgenerate

  irq_prio u_prio (
    .ok_i    (ok),
    .valid_o (valid),
    .idx_o   (idx)
  );

  irq_ctrl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_set_i     (en_set_i),
    .en_clr_i     (en_clr_i),
    .take_mask_i  (take_mask),
    .apply_i      (cfg_we_i & cfg_wdata_i[CFG_APPLY]),
    .mask_wdata_i (cfg_wdata_i[N_MASK-1:0]),
    .nap_i        (nap_i),
    .wake_i       (pend[SRC_NM]),
    .ie_o         (ie),
    .mask_o       (mask),
    .napping_o    (napping_o)
  );

  assign ack_d = take & (idx == IDX_W'(SRC_EXT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign irq_pend_o = valid;
  assign irq_vec_o  = valid ? vec_of(idx) : '0;
  assign ext_ack_o  = ack_q;
  assign status_o   = {1'b0, pend[SRC_HI], pend[SRC_MID], pend[SRC_LO], ie, mask};
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nm_pend,
  input logic        irq_pend,
  input logic [15:0] irq_vec,
  input logic        accept,
  input logic [7:0]  status,
  input logic        ext_ack,
  input logic        napping
);
  AST_NM_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    nm_pend |-> (irq_pend && irq_vec == 16'h0024)); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[3] && !nm_pend) |-> !irq_pend); // R8
  AST_ACCEPT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && irq_pend && irq_vec != 16'h0024) |=> !status[3]); // R9
  AST_EXT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && irq_pend && irq_vec == 16'h0000) |=> ext_ack); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |=> !ext_ack); // R6
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    nm_pend |=> !napping); // R11
endmodule

bind vect_irq_ctrl irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nm_pend  (pend[0]),
  .irq_pend (irq_pend_o),
  .irq_vec  (irq_vec_o),
  .accept   (accept_i),
  .status   (status_o),
  .ext_ack  (ext_ack_o),
  .napping  (napping_o)
);

// File: tb/vect_irq_ctrl_test.sv
`timescale 1ns/1ps
module vect_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nm = 0, hi = 0, mid = 0, lo = 0, ext = 0, acc = 0, es = 0, ec = 0, we = 0, nap = 0;
  logic [7:0]  wd = '0;
  logic        pend_o, ack_o, napping;
  logic [15:0] vec_o;
  logic [7:0]  stat_o;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  typedef struct {
    bit req; logic [15:0] vec; logic [7:0] stat; bit ack; bit nap; string tag;
  } exp_t;
  exp_t q[$];
  exp_t it;

  always #10 clk = ~clk;

  vect_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .nm_req_i(nm), .vq_hi_i(hi), .vq_mid_i(mid),
    .vq_lo_i(lo), .ext_req_i(ext), .accept_i(acc), .en_set_i(es), .en_clr_i(ec),
    .cfg_we_i(we), .cfg_wdata_i(wd), .nap_i(nap), .irq_pend_o(pend_o),
    .irq_vec_o(vec_o), .ext_ack_o(ack_o), .status_o(stat_o), .napping_o(napping)
  );

  task automatic tick(input bit r, input logic [15:0] v, input logic [7:0] s,
                      input bit a, input bit n, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.req = r; e.vec = v; e.stat = s; e.ack = a; e.nap = n; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] d, input bit r, input logic [15:0] v,
                     input logic [7:0] s, input bit n, input string tag);
    we = 1; wd = d;
    tick(r, v, s, 0, n, tag);
    we = 0; wd = '0;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      it = q.pop_front();
      n_run++;
      if (pend_o !== it.req || vec_o !== it.vec || stat_o !== it.stat ||
          ack_o !== it.ack || napping !== it.nap) begin
        n_fail++;
        $display("FAIL %s: got req=%0b vec=%h stat=%h ack=%0b nap=%0b exp req=%0b vec=%h stat=%h ack=%0b nap=%0b",
                 it.tag, pend_o, vec_o, stat_o, ack_o, napping,
                 it.req, it.vec, it.stat, it.ack, it.nap);
      end
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (pend_o !== 1'b0 || stat_o !== 8'h07 || ack_o !== 1'b0 || napping !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: got req=%0b stat=%h exp req=0 stat=07", pend_o, stat_o);
    end
    rst_n = 1;
    tick(0, 16'h0000, 8'h07, 0, 0, "R1 after reset");
    // non-maskable source with enable clear and all masks set
    nm = 1; tick(1, 16'h0024, 8'h07, 0, 0, "R2 edge+level");
    acc = 1; tick(0, 16'h0000, 8'h07, 0, 0, "R2 accepted");
    acc = 0; tick(0, 16'h0000, 8'h07, 0, 0, "R2 held high no retrigger");
    nm = 0; tick(0, 16'h0000, 8'h07, 0, 0, "R2 low");
    nm = 1; tick(1, 16'h0024, 8'h07, 0, 0, "R2 second edge");
    nm = 0; tick(0, 16'h0000, 8'h07, 0, 0, "R2 level dropped");
    nm = 1; tick(1, 16'h0024, 8'h07, 0, 0, "R2 third edge");
    acc = 1; tick(0, 16'h0000, 8'h07, 0, 0, "R2 accept again");
    acc = 0; nm = 0; tick(0, 16'h0000, 8'h07, 0, 0, "R2 idle");
    // masks and enable
    cfg(8'h08, 0, 16'h0000, 8'h00, 0, "R7 unmask all");
    mid = 1; tick(0, 16'h0000, 8'h20, 0, 0, "R8 disabled blocks mid");
    es = 1; tick(1, 16'h0034, 8'h28, 0, 0, "R5 mid vector");
    es = 0; ec = 1; tick(0, 16'h0000, 8'h20, 0, 0, "R8 clear enable");
    ec = 0; es = 1; tick(1, 16'h0034, 8'h28, 0, 0, "R8 set enable");
    es = 0; acc = 1; tick(0, 16'h0000, 8'h20, 0, 0, "R9 accept clears enable");
    acc = 0; mid = 0; tick(0, 16'h0000, 8'h00, 0, 0, "R5 mid level gone");
    // latched high input
    cfg(8'h0C, 0, 16'h0000, 8'h04, 0, "R7 mask high");
    hi = 1; tick(0, 16'h0000, 8'h44, 0, 0, "R3 edge latched while masked");
    hi = 0; tick(0, 16'h0000, 8'h44, 0, 0, "R3 latch holds after fall");
    es = 1; tick(0, 16'h0000, 8'h4C, 0, 0, "R7 masked no request");
    es = 0; cfg(8'h08, 1, 16'h003C, 8'h48, 0, "R3 high vector");
    acc = 1; tick(0, 16'h0000, 8'h00, 0, 0, "R4 accept clears latch");
    acc = 0; hi = 1; tick(0, 16'h0000, 8'h40, 0, 0, "R3 edge while disabled");
    hi = 0; cfg(8'h17, 0, 16'h0000, 8'h00, 0, "R4 flush, R7 masks kept");
    // priority stack
    es = 1; tick(0, 16'h0000, 8'h08, 0, 0, "R8 enable");
    es = 0; lo = 1; mid = 1; ext = 1; tick(1, 16'h0034, 8'h38, 0, 0, "R10 mid over lo/ext");
    hi = 1; tick(1, 16'h003C, 8'h78, 0, 0, "R10 high over mid");
    hi = 0; nm = 1; tick(1, 16'h0024, 8'h78, 0, 0, "R10 trap over all");
    acc = 1; tick(1, 16'h003C, 8'h78, 0, 0, "R9 trap accept keeps enable");
    acc = 0; nm = 0; tick(1, 16'h003C, 8'h78, 0, 0, "R10 high remains");
    acc = 1; tick(0, 16'h0000, 8'h30, 0, 0, "R4 high accepted");
    acc = 0; es = 1; tick(1, 16'h0034, 8'h38, 0, 0, "R10 mid again");
    es = 0; cfg(8'h0A, 1, 16'h002C, 8'h3A, 0, "R5 lo vector");
    cfg(8'h0B, 1, 16'h0000, 8'h3B, 0, "R6 general request");
    acc = 1; tick(0, 16'h0000, 8'h33, 1, 0, "R6 ack strobe");
    acc = 0; tick(0, 16'h0000, 8'h33, 0, 0, "R6 ack single cycle");
    lo = 0; mid = 0; ext = 0; tick(0, 16'h0000, 8'h03, 0, 0, "R5 levels gone");
    // power-down
    nap = 1; tick(0, 16'h0000, 8'h03, 0, 1, "R11 enter nap");
    nap = 0; es = 1; tick(0, 16'h0000, 8'h0B, 0, 1, "R11 still napping");
    es = 0; cfg(8'h08, 0, 16'h0000, 8'h08, 1, "R7 unmask");
    mid = 1; tick(1, 16'h0034, 8'h28, 0, 1, "R11 maskable no wake");
    mid = 0; tick(0, 16'h0000, 8'h08, 0, 1, "R11 nap held");
    nm = 1; tick(1, 16'h0024, 8'h08, 0, 1, "R11 trap seen");
    tick(1, 16'h0024, 8'h08, 0, 0, "R11 trap wakes");
    acc = 1; tick(0, 16'h0000, 8'h08, 0, 0, "R2 accept");
    acc = 0; nm = 0; tick(0, 16'h0000, 8'h08, 0, 0, "R2 idle end");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule